// File: doc/BRIEF.md
# I2C Command-Driven Transfer Sequencer

This block is an I2C bus master run from a single command word. Software presents a target address, a direction, a byte count, an optional one-byte index and three flags: end with STOP, allow a wait state, and send the index first. One strobe of that word with the go bit set starts a cycle. The engine then generates START, the address byte, an optional index write followed by a repeated START, the data bytes, and finally a STOP or a wait state that parks SCL low until the next command arrives.

Data moves through one 32-bit data register, four bytes at a time. The engine pauses with SCL held low whenever the register has to be refilled for a write or drained for a read. A ready flag and a go flag report where the cycle stands. A sticky NACK flag records a target that refused a byte. Both bus lines are open drain: the outputs only ask for a line to be pulled low. A programmable divider sets the bit rate, and each bit takes four divider ticks.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command strobe with the go bit set starts a cycle only when `rdy` is 1, `go` is 0, the count is non-zero, and the index flag is either clear or set together with the wait flag. Any other command strobe with the go bit set leaves `rdy`, `go` and both bus lines unchanged.
- R2: From the cycle after a command is accepted, `go` reads 1 and `rdy` reads 0 until the cycle ends. `go` returns to 0 on its own, no later than the cycle in which `rdy` returns to 1.
- R3: The address byte is the 7-bit address followed by the direction bit in the least significant position (1 = read), sent MSB first. A target acknowledges by holding SDA low in the ninth bit. Each bit spans four divider ticks. Within a byte, SDA changes only while SCL is low.
- R4: With the index flag set, the engine sends the address with the direction bit at 0, then the index byte, then a repeated START, then the address again with the commanded direction, and then the data phase.
- R5: With the STOP flag set, a STOP condition follows the last data byte. The bus is then released and `rdy` reads 1.
- R6: With the STOP flag clear and the wait flag set, the engine holds SCL low after the last byte and sends no STOP, and `rdy` reads 1. The next accepted command begins with a repeated START.
- R7: Exactly the commanded number of data bytes is transferred. On reads the master acknowledges every byte except the last one, which it answers with a NACK.
- R8: Data byte k of a cycle uses bits [8*(k mod 4)+7 : 8*(k mod 4)] of the data register. After every fourth byte that is not the last, the engine raises `dat_req` and holds SCL low, with `rdy` at 0. It resumes on a data-register write for a write cycle, or on a data-register read strobe for a read cycle.
- R9: A NACK on the address byte, the index byte or a written data byte sets `nack` and holds SCL low with `rdy` at 1. `nack` stays set through a STOP and clears only when the next command is accepted.
- R10: A command strobe with the STOP flag set and the go bit clear, sent while the engine is paused (wait state, NACK pause or data request), ends the transfer with a STOP. This stop request wins over a data-register write or read in the same cycle.
- R11: After reset, `rdy` is 1, `go`, `nack` and `dat_req` are 0, and neither bus line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Divider limit; one tick every clk_div+1 clocks |
| cmd_we | input | 1 | Command word strobe |
| cmd_go | input | 1 | Start a cycle |
| cmd_stop | input | 1 | End the cycle with STOP (with go clear: stop request) |
| cmd_wait | input | 1 | Allow the wait state after the cycle |
| cmd_idx | input | 1 | Send the index byte first |
| cmd_rd | input | 1 | Direction of the main transaction, 1 = read |
| cmd_addr | input | 7 | Target address |
| cmd_index | input | 8 | Index byte |
| cmd_count | input | CNT_W | Data-phase byte count |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 32 | Data register write value |
| dat_re | input | 1 | Data register read strobe (drains a read pause) |
| dat_rdata | output | 32 | Data register contents |
| rdy | output | 1 | Controller ready |
| go | output | 1 | Go bit, cleared by hardware |
| nack | output | 1 | Sticky NACK status |
| dat_req | output | 1 | Data register service needed |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The case of interest is a data-register write and a stop request landing on the same clock while the engine waits for a refill. A write of eight bytes is started and the bench waits for `dat_req`. It then drives `dat_we` with fresh data and a stop-only command strobe on the same clock. The target model's record of the bus is correct only if exactly four data bytes appear, followed directly by a STOP, and if the refilled data never reaches the bus.

// File: rtl/i2c_cmd_seq.sv
`timescale 1ns/1ps
module i2c_cmd_seq #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_we,
  input  logic             cmd_go,
  input  logic             cmd_stop,
  input  logic             cmd_wait,
  input  logic             cmd_idx,
  input  logic             cmd_rd,
  input  logic [6:0]       cmd_addr,
  input  logic [7:0]       cmd_index,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             dat_we,
  input  logic [31:0]      dat_wdata,
  input  logic             dat_re,
  output logic [31:0]      dat_rdata,
  output logic             rdy,
  output logic             go,
  output logic             nack,
  output logic             dat_req,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);

  typedef enum logic [3:0] {
    S_IDLE, S_STA, S_RST, S_ADR, S_IDX, S_DAT, S_DWT, S_HLD, S_NST, S_STP
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] divcnt;
  logic [1:0]       ph, bsel;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [31:0]      dreg;
  logic [CNT_W-1:0] rem;
  logic             c_rd, c_stop, c_wait, pre, ackb;
  logic [6:0]       c_addr;
  logic [7:0]       c_index;

  wire active  = st inside {S_STA, S_RST, S_ADR, S_IDX, S_DAT, S_STP};
  wire is_byte = st inside {S_ADR, S_IDX, S_DAT};
  wire tick    = active && (divcnt == clk_div);
  wire last_ph = tick && (ph == 2'd3);
  wire rd_byte = (st == S_DAT) && c_rd;
  wire ack_out = rem != CNT_W'(1);
  wire [1:0] nxt = bsel + 2'd1;

  assign rdy       = st inside {S_IDLE, S_HLD, S_NST};
  assign dat_req   = st == S_DWT;
  assign dat_rdata = dreg;

  wire acc      = cmd_we && cmd_go && rdy && !go && (cmd_count != '0) && (cmd_wait || !cmd_idx);
  wire stop_req = cmd_we && cmd_stop && !cmd_go && (st inside {S_HLD, S_NST, S_DWT});

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_STA: begin scl_oe = ph == 2'd3; sda_oe = ph[1]; end
      S_RST: begin scl_oe = (ph == 2'd0) || (ph == 2'd3); sda_oe = ph[1]; end
      S_ADR, S_IDX, S_DAT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rd_byte && ack_out) : (!rd_byte && !sh[7]);
      end
      S_STP: begin scl_oe = ph == 2'd0; sda_oe = !ph[1]; end
      S_DWT, S_HLD, S_NST: scl_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt <= '0;
      ph     <= '0;
    end else begin
      divcnt <= (!active || tick) ? '0 : divcnt + 1'b1;
      ph     <= !active ? 2'd0 : (tick ? ph + 2'd1 : ph);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go <= 1'b0; nack <= 1'b0; bsel <= '0; bitn <= '0;
      sh <= '0; dreg <= '0; rem <= '0; ackb <= 1'b0; pre <= 1'b0;
      c_rd <= 1'b0; c_stop <= 1'b0; c_wait <= 1'b0; c_addr <= '0; c_index <= '0;
    end else begin
      if (dat_we && !active) dreg <= dat_wdata;
      if (acc) begin
        c_rd <= cmd_rd; c_stop <= cmd_stop; c_wait <= cmd_wait;
        c_addr <= cmd_addr; c_index <= cmd_index;
        go <= 1'b1; nack <= 1'b0; pre <= cmd_idx;
        rem <= cmd_count; bsel <= '0; bitn <= '0;
        st <= (st == S_IDLE) ? S_STA : S_RST;
      end else if (stop_req) begin
        st <= S_STP;
      end else begin
        case (st)
          S_STA, S_RST:
            if (last_ph) begin
              st <= S_ADR; sh <= {c_addr, c_rd && !pre}; bitn <= '0;
            end
          S_ADR, S_IDX, S_DAT: begin
            if (tick && ph == 2'd2) begin
              if (bitn == 4'd8) ackb <= sda_in;
              else if (rd_byte) sh <= {sh[6:0], sda_in};
            end
            if (last_ph) begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1;
                if (!rd_byte) sh <= {sh[6:0], 1'b0};
              end else begin
                bitn <= '0;
                if (st == S_ADR) begin
                  if (ackb) begin nack <= 1'b1; go <= 1'b0; st <= S_NST; end
                  else if (pre) begin st <= S_IDX; sh <= c_index; end
                  else begin st <= S_DAT; sh <= dreg[7:0]; end
                end else if (st == S_IDX) begin
                  if (ackb) begin nack <= 1'b1; go <= 1'b0; st <= S_NST; end
                  else begin pre <= 1'b0; st <= S_RST; end
                end else begin
                  if (c_rd) dreg[{bsel, 3'b000} +: 8] <= sh;
                  rem  <= rem - 1'b1;
                  bsel <= nxt;
                  if (!c_rd && ackb) begin
                    nack <= 1'b1; go <= 1'b0; st <= S_NST;
                  end else if (rem == CNT_W'(1)) begin
                    if (c_stop || !c_wait) st <= S_STP;
                    else begin st <= S_HLD; go <= 1'b0; end
                  end else if (bsel == 2'd3) st <= S_DWT;
                  else sh <= dreg[{nxt, 3'b000} +: 8];
                end
              end
            end
          end
          S_DWT:
            if (c_rd ? dat_re : dat_we) begin
              st <= S_DAT; bitn <= '0;
              if (!c_rd) sh <= dat_wdata[7:0];
            end
          S_STP:
            if (last_ph) begin st <= S_IDLE; go <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  AST_GO_NOT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !rdy);                                                    // R2
  AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> ($past(rdy) && $past(cmd_we) && $past(cmd_go)));   // R1
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_byte && $past(is_byte) && (sda_oe != $past(sda_oe))) |-> (scl_oe && $past(scl_oe))); // R3
  AST_IDX_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> c_wait);                                                 // R4
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HLD) |-> (c_wait && !c_stop));                          // R6
  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DAT) |-> (rem != '0));                                  // R7
  AST_DREQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req |-> go);                                                 // R8
  AST_NACK_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> (st == S_NST));                                  // R9

endmodule

// File: tb/sim_i2c_cmd_seq.sv
`timescale 1ns/1ps
module sim_i2c_cmd_seq;
  localparam logic [6:0] TA = 7'h50;
  localparam logic [9:0] LS = 10'h200, LP = 10'h201;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  clk_div = 8'd1;
  logic        cmd_we = 0, cmd_go = 0, cmd_stop = 0, cmd_wait = 0, cmd_idx = 0, cmd_rd = 0;
  logic [6:0]  cmd_addr = '0;
  logic [7:0]  cmd_index = '0;
  logic [8:0]  cmd_count = '0;
  logic        dat_we = 0, dat_re = 0;
  logic [31:0] dat_wdata = '0, dat_rdata;
  logic        rdy, go, nack, dat_req, scl_oe, sda_oe;
  logic        t_low = 1'b0;
  logic        scl_w, sda_w;
  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || t_low);

  i2c_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_stop(cmd_stop), .cmd_wait(cmd_wait),
    .cmd_idx(cmd_idx), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_index(cmd_index),
    .cmd_count(cmd_count), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
    .dat_rdata(dat_rdata), .rdy(rdy), .go(go), .nack(nack), .dat_req(dat_req),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  int n_chk = 0, n_fail = 0;
  logic [9:0] lg [64];
  logic [9:0] ex [64];
  int ln = 0, en = 0;

  int   t_bit = 0, t_wcnt = 0, nack_at = -1;
  logic t_pos = 0, t_addr = 0, t_rd = 0, t_sel = 0, t_act = 0, t_wfirst = 0, t_mack = 0;
  logic [7:0] t_sh = '0, t_out = '0, t_ptr = '0;

  task automatic push(input logic [9:0] v);
    if (ln < 64) begin lg[ln] = v; ln++; end
  endtask

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    push(LS); t_bit = 0; t_pos = 0; t_addr = 1; t_low = 0; t_act = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    push(LP); t_low = 0; t_act = 0; t_addr = 0;
  end
  always @(posedge scl_w) begin
    t_pos = 1;
    if (t_bit < 8) t_sh = {t_sh[6:0], sda_w};
    else begin push({1'b0, sda_w, t_sh}); t_mack = sda_w; end
  end
  always @(negedge scl_w) if (t_pos) begin
    t_pos = 0;
    if (t_bit == 7) begin
      t_bit = 8;
      if (t_addr) begin
        t_rd = t_sh[0]; t_sel = (t_sh[7:1] == TA); t_low = t_sel;
        if (!t_rd) t_wfirst = 1;
      end else if (!t_rd) begin
        if (t_sel) begin
          if (t_wfirst) begin t_ptr = t_sh; t_wfirst = 0; end
          t_low = (t_wcnt != nack_at); t_wcnt++;
        end
      end else t_low = 0;
    end else if (t_bit == 8) begin
      t_bit = 0;
      if (t_addr) begin t_addr = 0; t_act = t_rd && t_sel; end
      else if (t_rd) t_act = t_act && !t_mack;
      if (t_act) begin t_out = t_ptr ^ 8'hA5; t_ptr = t_ptr + 8'd1; t_low = !t_out[7]; end
      else t_low = 0;
    end else begin
      t_bit++;
      if (t_act) t_low = !t_out[7 - t_bit];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    ln = 0; en = 0; t_wcnt = 0; nack_at = -1;
  endtask
  task automatic ea(input logic [9:0] v);
    ex[en] = v; en++;
  endtask
  function automatic logic [9:0] bt(input logic [7:0] b, input logic a);
    return {1'b0, a, b};
  endfunction
  task automatic lchk(input string tag);
    int bad = -1;
    if (ln != en) bad = 64;
    else for (int i = 0; i < en; i++) if (bad < 0 && lg[i] !== ex[i]) bad = i;
    n_chk++;
    if (bad == 64) begin
      n_fail++; $display("FAIL %s bus log length actual=%0d expected=%0d", tag, ln, en);
    end else if (bad >= 0) begin
      n_fail++; $display("FAIL %s bus log entry %0d actual=%h expected=%h", tag, bad, lg[bad], ex[bad]);
    end
  endtask

  task automatic cmd(input bit g, s, w, ix, rd, input logic [6:0] a,
                     input logic [7:0] ib, input logic [8:0] cnt);
    @(negedge clk);
    cmd_go = g; cmd_stop = s; cmd_wait = w; cmd_idx = ix; cmd_rd = rd;
    cmd_addr = a; cmd_index = ib; cmd_count = cnt; cmd_we = 1;
    @(negedge clk);
    cmd_we = 0;
  endtask
  task automatic dwr(input logic [31:0] d);
    @(negedge clk); dat_wdata = d; dat_we = 1;
    @(negedge clk); dat_we = 0;
  endtask
  task automatic drd();
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0;
  endtask
  task automatic wait_on(input int kind, input string tag);
    int k = 0;
    while (k < 30000) begin
      @(negedge clk);
      if (kind == 0 && rdy && !scl_oe) break;
      if (kind == 1 && rdy) break;
      if (kind == 2 && dat_req) break;
      k++;
    end
    if (k >= 30000) chk({tag, " wait timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    chk("R11 rdy", rdy, 1); chk("R11 go", go, 0); chk("R11 nack", nack, 0);
    chk("R11 dat_req", dat_req, 0); chk("R11 scl_oe", scl_oe, 0); chk("R11 sda_oe", sda_oe, 0);
  endtask

  task automatic t_write3();
    clr(); dwr(32'h00332211);
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd3);
    chk("R2 rdy low after go", rdy, 0); chk("R2 go high", go, 1);
    cmd(1, 1, 0, 0, 1, 7'h11, 8'h00, 9'd1);
    chk("R1 busy go ignored", go, 1);
    wait_on(0, "R5");
    chk("R2 go cleared", go, 0); chk("R5 rdy", rdy, 1);
    ea(LS); ea(bt(8'hA0, 0)); ea(bt(8'h11, 0)); ea(bt(8'h22, 0)); ea(bt(8'h33, 0)); ea(LP);
    lchk("R3 R5 R7 write3");
  endtask

  task automatic t_idxread();
    clr();
    cmd(1, 1, 1, 1, 1, TA, 8'h10, 9'd2);
    wait_on(0, "R4");
    chk("R8 read lanes", dat_rdata[15:0], 16'hB4B5);
    ea(LS); ea(bt(8'hA0, 0)); ea(bt(8'h10, 0)); ea(LS); ea(bt(8'hA1, 0));
    ea(bt(8'hB5, 0)); ea(bt(8'hB4, 1)); ea(LP);
    lchk("R4 R7 index read");
  endtask

  task automatic t_write6();
    clr(); dwr(32'h44332211);
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd6);
    wait_on(2, "R8");
    chk("R8 dat_req", dat_req, 1); chk("R8 rdy low in refill", rdy, 0);
    chk("R8 scl held", scl_oe, 1);
    dwr(32'h00006655);
    wait_on(0, "R8");
    ea(LS); ea(bt(8'hA0, 0));
    ea(bt(8'h11, 0)); ea(bt(8'h22, 0)); ea(bt(8'h33, 0)); ea(bt(8'h44, 0));
    ea(bt(8'h55, 0)); ea(bt(8'h66, 0)); ea(LP);
    lchk("R8 write refill");
  endtask

  task automatic t_read5();
    clr();
    cmd(1, 1, 1, 1, 1, TA, 8'h20, 9'd5);
    wait_on(2, "R8");
    chk("R8 read word", dat_rdata, 32'h86878485);
    drd();
    wait_on(0, "R8");
    chk("R8 read tail", dat_rdata[7:0], 8'h81);
    ea(LS); ea(bt(8'hA0, 0)); ea(bt(8'h20, 0)); ea(LS); ea(bt(8'hA1, 0));
    ea(bt(8'h85, 0)); ea(bt(8'h84, 0)); ea(bt(8'h87, 0)); ea(bt(8'h86, 0)); ea(bt(8'h81, 1)); ea(LP);
    lchk("R7 R8 read drain");
  endtask

  task automatic t_hold();
    bit low = 1;
    clr(); dwr(32'h00000077);
    cmd(1, 0, 1, 0, 0, TA, 8'h00, 9'd1);
    wait_on(1, "R6");
    chk("R6 rdy in wait", rdy, 1); chk("R6 go cleared", go, 0);
    repeat (100) begin @(negedge clk); if (!scl_oe) low = 0; end
    chk("R6 scl held low", low, 1);
    chk("R6 no stop yet", ln, 3);
    cmd(1, 1, 0, 0, 1, TA, 8'h00, 9'd1);
    wait_on(0, "R6");
    ea(LS); ea(bt(8'hA0, 0)); ea(bt(8'h77, 0));
    ea(LS); ea(bt(8'hA1, 0)); ea(bt(8'hD2, 1)); ea(LP);
    lchk("R6 restart after wait");
  endtask

  task automatic t_reject();
    clr();
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd0);
    chk("R1 zero count go", go, 0); chk("R1 zero count rdy", rdy, 1);
    cmd(1, 1, 0, 1, 1, TA, 8'h00, 9'd1);
    chk("R1 index without wait go", go, 0);
    repeat (200) @(negedge clk);
    chk("R1 bus untouched", ln, 0); chk("R1 scl released", scl_oe, 0);
  endtask

  task automatic t_nack_addr();
    clr();
    cmd(1, 1, 0, 0, 0, 7'h22, 8'h00, 9'd1);
    wait_on(1, "R9");
    chk("R9 nack set", nack, 1); chk("R9 scl paused", scl_oe, 1);
    cmd(0, 1, 0, 0, 0, 7'h00, 8'h00, 9'd0);
    wait_on(0, "R9");
    chk("R9 nack sticky", nack, 1);
    ea(LS); ea(bt(8'h44, 1)); ea(LP);
    lchk("R9 address nack");
    dwr(32'h00000099);
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd1);
    chk("R9 nack cleared on go", nack, 0);
    wait_on(0, "R9");
  endtask

  task automatic t_wnack();
    clr(); nack_at = 1; dwr(32'h00332211);
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd3);
    wait_on(1, "R9");
    chk("R9 data nack", nack, 1);
    cmd(0, 1, 0, 0, 0, 7'h00, 8'h00, 9'd0);
    wait_on(0, "R9");
    ea(LS); ea(bt(8'hA0, 0)); ea(bt(8'h11, 0)); ea(bt(8'h22, 1)); ea(LP);
    lchk("R9 write data nack");
  endtask

  task automatic t_cut();
    clr(); dwr(32'h04030201);
    cmd(1, 1, 0, 0, 0, TA, 8'h00, 9'd8);
    wait_on(2, "R10");
    @(negedge clk);
    cmd_go = 0; cmd_stop = 1; cmd_we = 1; dat_wdata = 32'h08070605; dat_we = 1;
    @(negedge clk);
    cmd_we = 0; dat_we = 0;
    wait_on(0, "R10");
    chk("R10 dat_req dropped", dat_req, 0); chk("R10 rdy", rdy, 1);
    ea(LS); ea(bt(8'hA0, 0));
    ea(bt(8'h01, 0)); ea(bt(8'h02, 0)); ea(bt(8'h03, 0)); ea(bt(8'h04, 0)); ea(LP);
    lchk("R10 stop beats refill");
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write3();
    t_idxread();
    t_write6();
    t_read5();
    t_hold();
    t_reject();
    t_nack_addr();
    t_wnack();
    t_cut();
    finish_run();
  end
endmodule